// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block is a register-mapped peripheral with two 8-bit parallel sides, A and B. A small synchronous register bus reaches it. Each side has a direction register, an output latch and a control register. Each side also watches two control lines. Line 1 is always an input. Line 2 is either a second input or an output. Edges on the input lines set status flags in the top two bits of the control register. Each flag has its own enable that gates it onto an active-low interrupt for that side.

One bus offset on each side is shared by the direction register and the output latch. A select bit in the control register chooses which one the offset reaches. Reading the data register clears both status flags of the side. When line 2 is an output, it can hold a fixed level or answer each data access with a handshake. On side A a data read starts the handshake. On side B a data write starts it.

Top module: `pport_ctrl`

## Requirements
- R1: After reset all four registers read 0, both interrupt outputs are high, no pin is an output and both line-2 output enables are low.
- R2: Offsets 0 and 1 are side A data and control, and offsets 2 and 3 are side B data and control. A data offset reaches the direction register when control bit 2 is 0 and the output latch when it is 1.
- R3: Direction bit 1 makes a pin an output. The direction and latch values appear on the pin direction and pin output ports. A data read returns the pin input for input bits and the latch for output bits.
- R4: An active edge on line 1 sets status bit 7 at the first clock edge that sees it. Control bit 1 chooses the edge: 0 for falling, 1 for rising. The other edge does not set the flag.
- R5: With control bit 5 at 0, an active edge on line 2 sets status bit 6. Control bit 4 chooses the edge: 0 for falling, 1 for rising.
- R6: The interrupt output of a side is low exactly while (bit 7 and control bit 0) or (bit 6 and control bit 3 and not control bit 5) holds. A flag sets even when its enable is 0.
- R7: A read of the data register (bit 2 = 1) clears bits 6 and 7 of that side. Reads of the control register or the direction register do not. A flag-setting edge in the same cycle as the clearing read wins.
- R8: With control bits 5:3 = 100, line 2 drives low for exactly one cycle after a triggering data access and is high otherwise. The trigger is a read on side A and a write on side B.
- R9: With control bits 5:3 = 101, line 2 goes low after a triggering data access and stays low until status bit 7 sets, returning high in the cycle the flag sets.
- R10: With control bits 5:4 = 11, line 2 drives the value of control bit 3. The line-2 output enable equals control bit 5.
- R11: While control bit 5 is 1, status bit 6 reads 0. A write of side B data does not clear side B flags.
- R12: Control bits 7 and 6 ignore bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register offset |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_a_n | output | 1 | Side A interrupt, active low |
| irq_b_n | output | 1 | Side B interrupt, active low |
| pa_in | input | 8 | Side A pin inputs |
| pa_out | output | 8 | Side A output latch |
| pa_dir | output | 8 | Side A pin output enables |
| ca1 | input | 1 | Side A line 1 |
| ca2_in | input | 1 | Side A line 2 input |
| ca2_out | output | 1 | Side A line 2 output value |
| ca2_oe | output | 1 | Side A line 2 output enable |
| pb_in | input | 8 | Side B pin inputs |
| pb_out | output | 8 | Side B output latch |
| pb_dir | output | 8 | Side B pin output enables |
| cb1 | input | 1 | Side B line 1 |
| cb2_in | input | 1 | Side B line 2 input |
| cb2_out | output | 1 | Side B line 2 output value |
| cb2_oe | output | 1 | Side B line 2 output enable |

## Verification
The bench checks that reads which should leave flags alone really do. A design that cleared on any access to the shared offset would lose a flag when only the direction register is read. It also drives a line-1 edge into the same cycle as a clearing read, where a design that let the clear win would drop the event. The two handshake modes are sampled cycle by cycle. This catches a pulse that lasts two cycles, a hold mode that releases before the flag, and a side B that starts its handshake on a read or clears its flag on a write. Status bit 6 is also read after line 2 is made an output, to catch a masked flag leaking through.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PORT_W = 8;
  localparam int CTL_W  = 6;

  // control bit positions (software-visible behaviour)
  localparam int C_IRQ1  = 0;
  localparam int C_EDGE1 = 1;
  localparam int C_SELD  = 2;
  localparam int C_L2B3  = 3;
  localparam int C_L2B4  = 4;
  localparam int C_L2OUT = 5;

  typedef enum logic [1:0] {
    L2_PULSE = 2'b00,
    L2_HOLD  = 2'b01,
    L2_LOW   = 2'b10,
    L2_HIGH  = 2'b11
  } l2_mode_e;

  function automatic logic [PORT_W-1:0] pin_view(input logic [PORT_W-1:0] pins,
                                                 input logic [PORT_W-1:0] latch,
                                                 input logic [PORT_W-1:0] dir);
    return (pins & ~dir) | (latch & dir);
  endfunction

  function automatic logic irq_level(input logic f7, input logic f6,
                                     input logic [CTL_W-1:0] c);
    return (f7 & c[C_IRQ1]) | (f6 & c[C_L2B3] & ~c[C_L2OUT]);
  endfunction

  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/pport_edge.sv
module pport_edge
  import pport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic rising,
  output logic hit
);
  logic prev_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= line;
      armed_q <= 1'b1;
    end
  end

  assign hit = armed_q & edge_hit(prev_q, line, rising);
endmodule

// File: rtl/pport_l2ctl.sv
module pport_l2ctl
  import pport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       out_en,
  input  logic [1:0] mode,
  input  logic       trig,
  input  logic       l1_hit,
  input  logic       ctl_wr,
  output logic       l2_out
);
  logic     hs_q;
  l2_mode_e m;
  logic     is_pulse;
  logic     is_hold;

  assign m        = l2_mode_e'(mode);
  assign is_pulse = out_en && (m == L2_PULSE);
  assign is_hold  = out_en && (m == L2_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n)                    hs_q <= 1'b1;
    else if (!is_pulse && !is_hold) hs_q <= 1'b1;
    else if (trig)                 hs_q <= 1'b0;
    else if (is_pulse)             hs_q <= 1'b1;
    else if (l1_hit)               hs_q <= 1'b1;
  end

  always_comb begin
    unique case (m)
      L2_LOW:  l2_out = 1'b0;
      L2_HIGH: l2_out = 1'b1;
      default: l2_out = hs_q;
    endcase
  end

  // R8: a pulse low lasts a single cycle
  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pulse && !l2_out && !trig && !ctl_wr) |=> l2_out);

  // R9: hold mode stays low until line 1 sets the flag
  assert_hold_until_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hold && !l2_out && !l1_hit && !ctl_wr) |=> !l2_out);
endmodule

// File: rtl/pport_side.sv
module pport_side
  import pport_pkg::*;
#(
  parameter int DW          = PORT_W,
  parameter bit HS_ON_WRITE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          reg_ctl,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_dir,
  input  logic          l1,
  input  logic          l2_in,
  output logic          l2_out,
  output logic          l2_oe,
  output logic          irq_n
);
  logic [DW-1:0]    ddr_q;
  logic [DW-1:0]    odr_q;
  logic [CTL_W-1:0] ctl_q;
  logic             f7_q;
  logic             f6_q;
  logic             l1_hit;
  logic             l2_hit;
  logic             data_sel;
  logic             data_rd;
  logic             data_wr;
  logic             ctl_wr;
  logic             hs_trig;
  logic [7:0]       status_view;

  assign data_sel = sel & ~reg_ctl & ctl_q[C_SELD];
  assign data_rd  = data_sel & rd;
  assign data_wr  = data_sel & wr;
  assign ctl_wr   = sel & wr & reg_ctl;
  assign hs_trig  = HS_ON_WRITE ? data_wr : data_rd;

  pport_edge i_edge1 (
    .clk(clk), .rst_n(rst_n), .line(l1), .rising(ctl_q[C_EDGE1]), .hit(l1_hit)
  );
  pport_edge i_edge2 (
    .clk(clk), .rst_n(rst_n), .line(l2_in), .rising(ctl_q[C_L2B4]), .hit(l2_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr_q <= '0;
      odr_q <= '0;
      ctl_q <= '0;
    end else begin
      if (sel && wr && !reg_ctl) begin
        if (ctl_q[C_SELD]) odr_q <= wdata;
        else               ddr_q <= wdata;
      end
      if (ctl_wr) ctl_q <= wdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f7_q <= 1'b0;
      f6_q <= 1'b0;
    end else begin
      if (l1_hit)       f7_q <= 1'b1;
      else if (data_rd) f7_q <= 1'b0;

      if (ctl_q[C_L2OUT]) f6_q <= 1'b0;
      else if (l2_hit)    f6_q <= 1'b1;
      else if (data_rd)   f6_q <= 1'b0;
    end
  end

  pport_l2ctl i_l2 (
    .clk(clk), .rst_n(rst_n), .out_en(ctl_q[C_L2OUT]),
    .mode(ctl_q[C_L2B4:C_L2B3]), .trig(hs_trig), .l1_hit(l1_hit),
    .ctl_wr(ctl_wr), .l2_out(l2_out)
  );

  assign status_view = {f7_q, f6_q & ~ctl_q[C_L2OUT], ctl_q};
  assign rdata   = reg_ctl ? DW'(status_view)
                 : (ctl_q[C_SELD] ? pin_view(pin_in, odr_q, ddr_q) : ddr_q);
  assign pin_out = odr_q;
  assign pin_dir = ddr_q;
  assign l2_oe   = ctl_q[C_L2OUT];
  assign irq_n   = ~irq_level(f7_q, f6_q, ctl_q);

  // R4: a detected line-1 edge always leaves the flag set
  assert_flag7_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l1_hit |=> f7_q);

  // R7: a data read with no competing edge clears the flag
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !l1_hit) |=> !f7_q);

  // R6: an enabled line-1 flag pulls the interrupt low
  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_hit && ctl_q[C_IRQ1] && !ctl_wr) |=> !irq_n);

  // R11: line 2 as output keeps its flag clear
  assert_flag6_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[C_L2OUT] |=> !f6_q);
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int DW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_a_n,
  output logic          irq_b_n,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  input  logic          ca1,
  input  logic          ca2_in,
  output logic          ca2_out,
  output logic          ca2_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  input  logic          cb1,
  input  logic          cb2_in,
  output logic          cb2_out,
  output logic          cb2_oe
);
  localparam int NSIDE = 2;

  logic [DW-1:0] s_rd   [NSIDE];
  logic [DW-1:0] s_out  [NSIDE];
  logic [DW-1:0] s_dir  [NSIDE];
  logic [NSIDE-1:0] s_l2o;
  logic [NSIDE-1:0] s_l2e;
  logic [NSIDE-1:0] s_irq;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    pport_side #(.DW(DW), .HS_ON_WRITE(g == 1)) i_side (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (cs && (addr[1] == g[0])),
      .reg_ctl(addr[0]),
      .rd     (rd),
      .wr     (wr),
      .wdata  (wdata),
      .rdata  (s_rd[g]),
      .pin_in ((g == 0) ? pa_in : pb_in),
      .pin_out(s_out[g]),
      .pin_dir(s_dir[g]),
      .l1     ((g == 0) ? ca1 : cb1),
      .l2_in  ((g == 0) ? ca2_in : cb2_in),
      .l2_out (s_l2o[g]),
      .l2_oe  (s_l2e[g]),
      .irq_n  (s_irq[g])
    );
  end

  assign rdata   = cs ? s_rd[addr[1]] : '0;
  assign pa_out  = s_out[0];
  assign pa_dir  = s_dir[0];
  assign pb_out  = s_out[1];
  assign pb_dir  = s_dir[1];
  assign ca2_out = s_l2o[0];
  assign ca2_oe  = s_l2e[0];
  assign cb2_out = s_l2o[1];
  assign cb2_oe  = s_l2e[1];
  assign irq_a_n = s_irq[0];
  assign irq_b_n = s_irq[1];
endmodule

// File: tb/test_pport_ctrl.sv
module test_pport_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_a_n, irq_b_n;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
  logic ca1 = 1'b0, ca2_in = 1'b0, cb1 = 1'b0, cb2_in = 1'b0;
  logic ca2_out, ca2_oe, cb2_out, cb2_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pport_ctrl i_pport_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir), .ca1(ca1),
    .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .cb1(cb1),
    .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe)
  );

  typedef struct packed {
    logic       is_wr;
    logic [1:0] a;
    logic [7:0] d;
  } vec_t;

  // pa_in = 3C, pb_in = C3 during the table
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 8'hF0},   // R2 direction A
    '{1'b0, 2'd0, 8'hF0},
    '{1'b1, 2'd1, 8'h04},   // R2 select latch
    '{1'b1, 2'd0, 8'hA5},
    '{1'b0, 2'd0, 8'hAC},   // R3 mixed view
    '{1'b0, 2'd1, 8'h04},
    '{1'b1, 2'd2, 8'h0F},   // R2 direction B
    '{1'b0, 2'd2, 8'h0F},
    '{1'b1, 2'd3, 8'h04},
    '{1'b1, 2'd2, 8'h5A},
    '{1'b0, 2'd2, 8'hCA},   // R3 mixed view B
    '{1'b1, 2'd1, 8'h00},
    '{1'b0, 2'd0, 8'hF0},   // R2 back to direction
    '{1'b1, 2'd1, 8'h04}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_rd(a, v);
    chk(v, exp, req);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    waitn(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd_chk(2'(i), 8'h00, "R1 register");
    chk({6'd0, irq_a_n, irq_b_n}, 8'h03, "R1 irq");
    chk({6'd0, ca2_oe, cb2_oe}, 8'h00, "R1 line2 oe");
    chk(pa_dir | pb_dir, 8'h00, "R1 dir");

    pa_in = 8'h3C; pb_in = 8'hC3;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) bus_wr(VEC[i].a, VEC[i].d);
      else rd_chk(VEC[i].a, VEC[i].d, "R2/R3 vector");
    end
    chk(pa_dir, 8'hF0, "R3 pa_dir");
    chk(pa_out, 8'hA5, "R3 pa_out");

    // R4 falling edge, interrupt disabled
    ca1 = 1'b1; waitn(1); ca1 = 1'b0; waitn(1);
    rd_chk(2'd1, 8'h84, "R4 falling sets bit7");
    chk({7'd0, irq_a_n}, 8'h01, "R6 flag without enable");
    rd_chk(2'd1, 8'h84, "R7 control read keeps flag");
    bus_wr(2'd1, 8'h00);
    rd_chk(2'd0, 8'hF0, "R2 direction view");
    rd_chk(2'd1, 8'h80, "R7 direction read keeps flag");
    bus_wr(2'd1, 8'h05);
    chk({7'd0, irq_a_n}, 8'h00, "R6 enabled irq");
    rd_chk(2'd0, 8'hAC, "R3 data read");
    rd_chk(2'd1, 8'h05, "R7 data read clears");
    chk({7'd0, irq_a_n}, 8'h01, "R6 irq released");

    // R4 rising edge select
    bus_wr(2'd1, 8'h06);
    ca1 = 1'b1; waitn(1);
    rd_chk(2'd1, 8'h86, "R4 rising sets bit7");
    bus_rd(2'd0, v);
    ca1 = 1'b0; waitn(2);
    rd_chk(2'd1, 8'h06, "R4 opposite edge ignored");

    // R5 line 2 input
    bus_wr(2'd1, 8'h1C);
    ca2_in = 1'b1; waitn(1);
    rd_chk(2'd1, 8'h5C, "R5 rising sets bit6");
    chk({7'd0, irq_a_n}, 8'h00, "R6 bit6 irq");
    bus_rd(2'd0, v);
    rd_chk(2'd1, 8'h1C, "R7 clears bit6");
    bus_wr(2'd1, 8'h04);
    ca2_in = 1'b0; waitn(1);
    rd_chk(2'd1, 8'h44, "R5 falling sets bit6");
    bus_wr(2'd1, 8'h24);
    rd_chk(2'd1, 8'h24, "R11 bit6 masked as output");
    chk({7'd0, ca2_oe}, 8'h01, "R10 oe follows bit5");

    // R8 side A pulse on read
    chk({7'd0, ca2_out}, 8'h01, "R8 idle high");
    bus_rd(2'd0, v);
    chk({7'd0, ca2_out}, 8'h00, "R8 pulse low");
    waitn(1);
    chk({7'd0, ca2_out}, 8'h01, "R8 pulse one cycle");
    bus_wr(2'd0, 8'hA5);
    chk({7'd0, ca2_out}, 8'h01, "R8 write no pulse on A");

    // R9 hold until flag
    bus_wr(2'd1, 8'h2C);
    bus_rd(2'd0, v);
    chk({7'd0, ca2_out}, 8'h00, "R9 low after read");
    waitn(3);
    chk({7'd0, ca2_out}, 8'h00, "R9 stays low");
    ca1 = 1'b1; waitn(1); ca1 = 1'b0; waitn(1);
    chk({7'd0, ca2_out}, 8'h01, "R9 released by flag");
    rd_chk(2'd1, 8'hAC, "R9 flag set");

    // R10 fixed levels
    bus_wr(2'd1, 8'h34);
    chk({7'd0, ca2_out}, 8'h00, "R10 fixed low");
    bus_wr(2'd1, 8'h3C);
    chk({7'd0, ca2_out}, 8'h01, "R10 fixed high");
    bus_wr(2'd1, 8'h04);
    chk({7'd0, ca2_oe}, 8'h00, "R10 oe off");

    // R12 read-only bits
    bus_rd(2'd0, v);
    bus_wr(2'd1, 8'hC4);
    rd_chk(2'd1, 8'h04, "R12 bits 7:6 ignore writes");

    // R7 set wins over clear
    ca1 = 1'b1; waitn(1);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = 2'd0; ca1 = 1'b0;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    rd_chk(2'd1, 8'h84, "R7 edge beats clear");

    // side B: write handshake, write does not clear
    bus_wr(2'd3, 8'h25);
    cb1 = 1'b1; waitn(1); cb1 = 1'b0; waitn(1);
    chk({7'd0, irq_b_n}, 8'h00, "R6 side B irq");
    chk({7'd0, cb2_out}, 8'h01, "R8 B idle high");
    bus_wr(2'd2, 8'h77);
    chk({7'd0, cb2_out}, 8'h00, "R8 B pulse on write");
    waitn(1);
    chk({7'd0, cb2_out}, 8'h01, "R8 B pulse one cycle");
    chk(pb_out, 8'h77, "R3 pb_out");
    rd_chk(2'd3, 8'hA5, "R11 B write keeps flag");
    chk({7'd0, irq_b_n}, 8'h00, "R11 B irq kept");
    bus_rd(2'd2, v);
    chk({7'd0, cb2_out}, 8'h01, "R8 B read no pulse");
    chk({7'd0, irq_b_n}, 8'h01, "R7 B read clears");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule